// File: doc/BRIEF.md
# Flash Status Auto-Polling Engine

This engine waits on a serial flash without processor involvement. A single start strobe captures a bit mask, a match value, a gap length and a cycle budget. The engine then asks a shared serial command sequencer for a slot through a request/grant handshake. In each slot it issues a read-status instruction that takes no address, uses one data line and returns one status byte. The engine tests that byte in AND mode, where a poll succeeds when the status bits selected by the mask equal the match value. It stops on the first success, or when the cycle budget runs out.

Two settings cover the usual flash sequences. To wait for the write-enable latch, set both mask and match to that latch bit. To wait for an operation to finish, set the mask to the write-in-progress bit and the match to zero. The budget is given with each start, so a sector erase or a whole-chip erase can be given a much longer wait than a register write. The last status byte received stays on an output for debug.

Top module: `fpoll_engine`

## Requirements
- R1: After reset, busy_o, seq_req_o, done_o, matched_o and timeout_o are 0 and status_o is 8'h00.
- R2: A start accepted while idle raises seq_req_o in the next cycle. seq_req_o stays high until the cycle in which seq_gnt_i is seen. seq_opcode_o always carries the read-status instruction code 8'h05.
- R3: A response byte is taken only in the cycle after a grant, or later while that poll is still waiting. A poll hits when (byte & mask) == match. A match bit outside the mask therefore never hits. A response that arrives while the engine is idle leaves status_o unchanged.
- R4: On the first hit, the engine drops busy_o, pulses done_o for exactly one cycle, sets matched_o and issues no further request.
- R5: After a response that does not hit, seq_req_o stays low for exactly N cycles before it rises again. N is the interval captured at start, and an interval of 0 selects 16.
- R6: With budget T, busy_o stays high for at most max(T,1) cycles. If no hit occurs in that time, the engine ends with a one-cycle done_o pulse and sets timeout_o.
- R7: If a hitting response arrives in the last cycle of the budget, the timeout wins: timeout_o is set and matched_o is clear.
- R8: A start while busy_o is high is ignored. The running poll keeps its original mask, match, interval and budget.
- R9: status_o takes every accepted response byte and holds it after completion. matched_o and timeout_o hold their value until the next accepted start, and they are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| mask_i | input | 8 | Status bits to compare |
| match_i | input | 8 | Value the masked status must equal |
| interval_i | input | 8 | Idle cycles between polls, 0 selects 16 |
| timeout_i | input | 24 | Cycle budget for the whole operation |
| seq_req_o | output | 1 | Request for a sequencer slot |
| seq_opcode_o | output | 8 | Instruction code to issue (read status) |
| seq_gnt_i | input | 1 | Sequencer accepts the request |
| seq_rsp_valid_i | input | 1 | Status byte valid from sequencer |
| seq_rsp_data_i | input | 8 | Status byte from sequencer |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle completion pulse |
| matched_o | output | 1 | Operation ended on a hit |
| timeout_o | output | 1 | Operation ended on budget expiry |
| status_o | output | 8 | Last status byte received |

## Verification
The bench drives several input patterns against a sequencer model with a fixed response latency.
- The write-enable-latch wait shows that the engine stops only once the latch bit is set.
- The write-in-progress wait shows that a zero match value is honoured.
- A status that hits on the first poll gives the exact end-to-end latency.
- A never-clearing status, and a match bit placed outside the mask, both end in timeout. The second case separates true AND-mode comparison from a comparison that masks both sides.
- Intervals of 0, 1 and larger values separate the default gap from a programmed gap.
- Two budgets, one cycle apart, place a hitting byte on and just inside the deadline to show which outcome wins.
- A delayed grant and a second start in mid-run show that the request is held and the configuration stays fixed.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
    typedef enum logic [1:0] {
        PS_IDLE,
        PS_REQ,
        PS_WAIT,
        PS_GAP
    } poll_state_e;
endpackage

// File: rtl/fpoll_match.sv
module fpoll_match #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] mask_i,
    input  logic [DW-1:0] match_i,
    output logic          hit_o
);
    logic [DW-1:0] bit_ok;

    // AND mode: a bit outside the mask must be zero in the match value
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign bit_ok[i] = ((status_i[i] & mask_i[i]) == match_i[i]);
    end

    assign hit_o = &bit_ok;
endmodule

// File: rtl/fpoll_gap_timer.sv
module fpoll_gap_timer #(
    parameter int IVL_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [IVL_W-1:0] len_i,
    input  logic             run_i,
    output logic             fire_o
);
    logic [IVL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // the last gap cycle is the one holding a count of one
    assign fire_o = run_i && (cnt_q <= IVL_W'(1));
endmodule

// File: rtl/fpoll_deadline.sv
module fpoll_deadline #(
    parameter int TMO_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expire_o
);
    logic [TMO_W-1:0] elapsed_d, elapsed_q;
    logic [TMO_W:0]   used;

    always_comb begin
        elapsed_d = elapsed_q;
        if (clear_i) begin
            elapsed_d = '0;
        end else if (run_i && (elapsed_q != '1)) begin
            elapsed_d = elapsed_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) elapsed_q <= '0;
        else         elapsed_q <= elapsed_d;
    end

    // cycles spent including the current one
    assign used     = {1'b0, elapsed_q} + 1'b1;
    assign expire_o = run_i && (used >= {1'b0, limit_i});
endmodule

// File: rtl/fpoll_engine.sv
module fpoll_engine #(
    parameter int          DW        = 8,
    parameter int          IVL_W     = 8,
    parameter int          TMO_W     = 24,
    parameter int          DEF_IVL   = 16,
    parameter logic [7:0]  STATUS_OP = 8'h05
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [DW-1:0]    mask_i,
    input  logic [DW-1:0]    match_i,
    input  logic [IVL_W-1:0] interval_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic             seq_req_o,
    output logic [7:0]       seq_opcode_o,
    input  logic             seq_gnt_i,
    input  logic             seq_rsp_valid_i,
    input  logic [DW-1:0]    seq_rsp_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             matched_o,
    output logic             timeout_o,
    output logic [DW-1:0]    status_o
);
    import fpoll_pkg::*;

    localparam logic [IVL_W-1:0] IVL_DEFAULT = IVL_W'(DEF_IVL);

    typedef struct packed {
        poll_state_e      st;
        logic [DW-1:0]    mask;
        logic [DW-1:0]    match;
        logic [DW-1:0]    last;
        logic [IVL_W-1:0] ivl;
        logic [TMO_W-1:0] limit;
        logic             done;
        logic             hit;
        logic             tmo;
    } regs_t;

    regs_t r_d, r_q;

    logic accept, rsp_take, hit_c, expire, gap_fire, gap_load, active;

    assign active   = (r_q.st != PS_IDLE);
    assign accept   = (r_q.st == PS_IDLE) && start_i;
    assign rsp_take = (r_q.st == PS_WAIT) && seq_rsp_valid_i;

    fpoll_match #(.DW(DW)) u_match (
        .status_i (seq_rsp_data_i),
        .mask_i   (r_q.mask),
        .match_i  (r_q.match),
        .hit_o    (hit_c)
    );

    fpoll_deadline #(.TMO_W(TMO_W)) u_deadline (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (accept),
        .run_i    (active),
        .limit_i  (r_q.limit),
        .expire_o (expire)
    );

    assign gap_load = rsp_take && !hit_c && !expire;

    fpoll_gap_timer #(.IVL_W(IVL_W)) u_gap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (gap_load),
        .len_i  (r_q.ivl),
        .run_i  (r_q.st == PS_GAP),
        .fire_o (gap_fire)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (rsp_take) r_d.last = seq_rsp_data_i;
        if (r_q.st == PS_IDLE) begin
            if (start_i) begin
                r_d.mask  = mask_i;
                r_d.match = match_i;
                r_d.ivl   = (interval_i == '0) ? IVL_DEFAULT : interval_i;
                r_d.limit = timeout_i;
                r_d.hit   = 1'b0;
                r_d.tmo   = 1'b0;
                r_d.st    = PS_REQ;
            end
        end else if (expire) begin
            // budget exhausted: wins over a hit in the same cycle
            r_d.st   = PS_IDLE;
            r_d.done = 1'b1;
            r_d.tmo  = 1'b1;
            r_d.hit  = 1'b0;
        end else begin
            case (r_q.st)
                PS_REQ:  if (seq_gnt_i) r_d.st = PS_WAIT;
                PS_WAIT: begin
                    if (rsp_take) begin
                        if (hit_c) begin
                            r_d.st   = PS_IDLE;
                            r_d.done = 1'b1;
                            r_d.hit  = 1'b1;
                        end else begin
                            r_d.st = PS_GAP;
                        end
                    end
                end
                PS_GAP:  if (gap_fire) r_d.st = PS_REQ;
                default: r_d.st = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.st    <= PS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign seq_req_o    = (r_q.st == PS_REQ);
    assign seq_opcode_o = STATUS_OP;
    assign busy_o       = active;
    assign done_o       = r_q.done;
    assign matched_o    = r_q.hit;
    assign timeout_o    = r_q.tmo;
    assign status_o     = r_q.last;
endmodule

// File: rtl/fpoll_engine_chk.sv
module fpoll_engine_chk #(
    parameter int DW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic          seq_req_o,
    input logic          seq_gnt_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          matched_o,
    input logic          timeout_o,
    input logic [DW-1:0] status_o
);
    // R2
    req_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_req_o |-> busy_o);

    // R2
    req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_req_o && !seq_gnt_i) |=> (seq_req_o || done_o));

    // R4
    done_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R4
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6
    fall_gives_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    // R7
    outcome_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (matched_o ^ timeout_o));

    // R9
    flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({matched_o, timeout_o}));

    // R9
    status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> $stable(status_o));
endmodule

bind fpoll_engine fpoll_engine_chk #(.DW(DW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .seq_req_o (seq_req_o),
    .seq_gnt_i (seq_gnt_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .matched_o (matched_o),
    .timeout_o (timeout_o),
    .status_o  (status_o)
);

// File: tb/fpoll_engine_tb.sv
module fpoll_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RXLAT      = 3;
    localparam int NVEC       = 6;

    typedef struct packed {
        logic [7:0]  mask;
        logic [7:0]  match;
        logic [7:0]  ivl;
        logic [23:0] tmo;
        logic [7:0]  nbusy;
        logic [7:0]  st_busy;
        logic [7:0]  st_final;
        logic        exp_hit;
        logic [7:0]  exp_last;
    } vec_t;

    // mask, match, interval, budget, non-hit polls, busy status, final status, hit, last
    localparam vec_t VECS [NVEC] = '{
        '{8'h02, 8'h02, 8'd0, 24'd2000, 8'd2,   8'h00, 8'h02, 1'b1, 8'h02},
        '{8'h01, 8'h00, 8'd4, 24'd2000, 8'd3,   8'h03, 8'h02, 1'b1, 8'h02},
        '{8'h01, 8'h00, 8'd5, 24'd2000, 8'd0,   8'h00, 8'h00, 1'b1, 8'h00},
        '{8'h01, 8'h00, 8'd3, 24'd60,   8'd255, 8'h01, 8'h01, 1'b0, 8'h01},
        '{8'h0F, 8'h10, 8'd2, 24'd40,   8'd255, 8'h10, 8'h10, 1'b0, 8'h10},
        '{8'h80, 8'h80, 8'd1, 24'd2000, 8'd4,   8'h7F, 8'hFF, 1'b1, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mask = '0, match = '0, ivl = '0;
    logic [23:0] tmo = '0;
    logic        req, gnt = 1'b0, rxv = 1'b0;
    logic [7:0]  rxd = '0, opcode, status;
    logic        busy, done, matched, timed_out;

    int n_chk = 0, n_fail = 0;
    int cycles = 0;
    bit wd = 1'b0;

    vec_t cur;
    int phase = 0, cnt = 0, reqhi = 0, gnt_delay = 0;
    int rx_total = 0, busy_total = 0, done_total = 0, base_rx = 0;
    int gap_n = 0, gap_bad = 0, gapc = 0, exp_gap = 16;
    bit meas = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpoll_engine u_dut (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start),
        .mask_i (mask), .match_i (match), .interval_i (ivl), .timeout_i (tmo),
        .seq_req_o (req), .seq_opcode_o (opcode), .seq_gnt_i (gnt),
        .seq_rsp_valid_i (rxv), .seq_rsp_data_i (rxd),
        .busy_o (busy), .done_o (done), .matched_o (matched),
        .timeout_o (timed_out), .status_o (status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // sequencer model and monitor, all on the falling edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000 && !wd) begin
            wd = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        end
        if (busy) busy_total++;
        if (done) done_total++;
        if (meas) begin
            if (!busy) meas = 1'b0;
            else if (req) begin
                gap_n++;
                if (gapc != exp_gap) gap_bad++;
                meas = 1'b0;
            end else gapc++;
        end
        gnt = 1'b0;
        rxv = 1'b0;
        if (phase == 0) begin
            if (req) begin
                reqhi++;
                if (reqhi > gnt_delay) begin
                    gnt = 1'b1; phase = 1; cnt = RXLAT; reqhi = 0;
                end
            end else reqhi = 0;
        end else begin
            if (cnt == 0) begin
                rxv = 1'b1;
                rxd = ((rx_total - base_rx) < int'(cur.nbusy)) ? cur.st_busy : cur.st_final;
                rx_total++;
                meas = 1'b1; gapc = 0; phase = 0;
            end else cnt--;
        end
    end

    task automatic launch(input vec_t v);
        @(negedge clk);
        mask = v.mask; match = v.match; ivl = v.ivl; tmo = v.tmo;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // runs one operation, then returns polls, busy cycles, done pulses, gap misses
    task automatic run(input vec_t v, input bit restart,
                       output int polls, output int bcyc, output int dcnt, output int gbad);
        int b0, d0, g0;
        cur = v;
        exp_gap = (v.ivl == 0) ? 16 : int'(v.ivl);
        base_rx = rx_total; b0 = busy_total; d0 = done_total; g0 = gap_bad;
        launch(v);
        if (restart) begin
            repeat (8) @(negedge clk);
            mask = 8'h00; match = 8'h00; ivl = 8'd1; tmo = 24'd2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_total == d0 && !wd) @(negedge clk);
        repeat (12) @(negedge clk);
        polls = rx_total - base_rx;
        bcyc  = busy_total - b0;
        dcnt  = done_total - d0;
        gbad  = gap_bad - g0;
    endtask

    task automatic check_vec(input vec_t v, input int polls, input int bcyc,
                             input int dcnt, input int gbad);
        chk(matched == v.exp_hit, "R4 matched flag", matched, v.exp_hit);
        chk(timed_out == !v.exp_hit, "R6 timeout flag", timed_out, !v.exp_hit);
        chk(status == v.exp_last, "R9 held status", status, v.exp_last);
        chk(dcnt == 1, "R4 one done pulse", dcnt, 1);
        chk(gbad == 0, "R5 gap length", gbad, 0);
        if (v.exp_hit) chk(polls == int'(v.nbusy) + 1, "R3 polls to first hit", polls, v.nbusy + 1);
        else           chk(bcyc == int'(v.tmo), "R6 busy cycles", bcyc, v.tmo);
    endtask

    initial begin
        int polls, bcyc, dcnt, gbad;
        vec_t dv;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, req, done, matched, timed_out} == 5'b0, "R1 reset flags",
            {busy, req, done, matched, timed_out}, 0);
        chk(status == 8'h00, "R1 reset status", status, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(opcode == 8'h05, "R2 opcode", opcode, 8'h05);

        for (int i = 0; i < NVEC; i++) begin
            run(VECS[i], 1'b0, polls, bcyc, dcnt, gbad);
            check_vec(VECS[i], polls, bcyc, dcnt, gbad);
        end
        chk(gap_n > 0, "R5 gaps observed", gap_n, 1);

        // R7 hit lands in the last budget cycle: timeout wins
        dv = '{8'h01, 8'h00, 8'd4, 24'd5, 8'd0, 8'h00, 8'h00, 1'b0, 8'h00};
        run(dv, 1'b0, polls, bcyc, dcnt, gbad);
        chk(timed_out == 1'b1 && matched == 1'b0, "R7 timeout priority", {matched, timed_out}, 1);
        chk(bcyc == 5, "R7 busy cycles", bcyc, 5);
        // R7 one more cycle of budget lets the hit through
        dv = '{8'h01, 8'h00, 8'd4, 24'd6, 8'd0, 8'h00, 8'h04, 1'b1, 8'h04};
        run(dv, 1'b0, polls, bcyc, dcnt, gbad);
        chk(matched == 1'b1 && timed_out == 1'b0, "R7 hit inside budget", {matched, timed_out}, 2);

        // R2 delayed grant: request held, latency grows by the delay
        gnt_delay = 6;
        dv = '{8'h01, 8'h00, 8'd4, 24'd500, 8'd0, 8'h00, 8'h00, 1'b1, 8'h00};
        run(dv, 1'b0, polls, bcyc, dcnt, gbad);
        chk(bcyc == 6 + RXLAT + 2, "R2 request held until grant", bcyc, 6 + RXLAT + 2);
        gnt_delay = 0;

        // R8 start in mid-run with a trivially hitting config is ignored
        dv = '{8'h01, 8'h00, 8'd4, 24'd2000, 8'd3, 8'h03, 8'h02, 1'b1, 8'h02};
        run(dv, 1'b1, polls, bcyc, dcnt, gbad);
        chk(polls == 4, "R8 restart ignored polls", polls, 4);
        chk(matched == 1'b1 && dcnt == 1, "R8 restart ignored outcome", {matched, dcnt[0]}, 3);

        // R6 zero budget ends after one cycle; R3 late response ignored
        dv = '{8'h01, 8'h00, 8'd4, 24'd0, 8'd0, 8'h00, 8'h55, 1'b0, 8'h00};
        run(dv, 1'b0, polls, bcyc, dcnt, gbad);
        chk(bcyc == 1 && timed_out == 1'b1, "R6 zero budget", bcyc, 1);
        chk(status == 8'h02, "R3 idle response ignored", status, 8'h02);

        // R9 flags and status persist while idle
        repeat (10) @(negedge clk);
        chk(timed_out == 1'b1 && status == 8'h02, "R9 hold while idle", status, 8'h02);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (wd);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule